// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Write-Cycle Timer

This block sits between a two-wire slave protocol engine and a byte-addressed storage array. The front end passes it decoded bus events: the word address of a write transaction, each data byte, a stop condition and a repeated start. The block collects the data bytes in a one-page buffer and marks each byte as it arrives. The write position advances inside the page and wraps back to the first byte of the same page.

A stop condition that ends a write carrying at least one data byte starts the commit. The block walks the page offsets in ascending order and writes only the marked bytes into the array. A programmable hold time in system clocks follows. For the whole commit and hold window, `busy` is high and every event input is ignored. A high write-protect input blocks all array writes. A repeated start discards the buffered transaction.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` and `arr_we` are low, and no array write happens until a write transaction completes.
- R2: A page is 2^PAGE_BITS bytes (32 by default), and the page row is `addr_in[ADDR_W-1:PAGE_BITS]`. Successive data bytes go to successive offsets `addr_in[PAGE_BITS-1:0]`, `+1`, and so on. Only the offset increments. After the last offset of the page, the next byte goes to offset 0 of the same row.
- R3: When more than one page of bytes arrives, a later byte that lands on an already filled offset replaces the earlier one. Only the last value written to each offset reaches the array.
- R4: The array is written only during the commit that follows a stop. Each offset that received a byte is written exactly once, with `arr_addr = {row, offset}`. Offsets that received no byte are not written and keep their contents.
- R5: `busy` rises on the clock edge that samples `stop_evt`, and only then. It stays high for exactly PAGE_BYTES + WR_CYCLES + 1 clocks.
- R6: While `busy` is high, `addr_we`, `byte_we`, `stop_evt` and `rstart_evt` have no effect. After the window closes, no further write cycle follows from them.
- R7: If `wp` is high when the stop is sampled, nothing is written and `busy` stays low. `arr_we` is never high while `wp` is high.
- R8: A `rstart_evt` received before the stop discards the buffered bytes. A later `stop_evt` then starts no write cycle.
- R9: A transaction that carries only an address, followed by a stop, starts no write cycle.
- R10: When `byte_we` and `stop_evt` arrive in the same cycle, that byte is part of the committed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect; high blocks all array writes |
| addr_we | input | 1 | Word address received; opens a write transaction |
| addr_in | input | ADDR_W | Starting word address |
| byte_we | input | 1 | Data byte received |
| byte_in | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition seen |
| rstart_evt | input | 1 | Repeated start seen; aborts the transaction |
| busy | output | 1 | Internal write cycle in progress; front end ignores the bus |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
Two functions can land in the same clock: capturing the final data byte into the buffer, and deciding at the stop whether to commit. The bench provokes this by pulsing `byte_we` and `stop_evt` together as the only data of a transaction. It then checks three things: the byte reaches the array, exactly one array write occurs, and the busy window has its full length. A missing byte would show up as a write cycle with no array write, or as no write cycle at all. The bench also pulses a complete write transaction while `busy` is high, and judges it by the unchanged array and a quiet `busy` afterwards.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5,
  parameter int WR_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_we,
  input  logic [7:0]        byte_in,
  input  logic              stop_evt,
  input  logic              rstart_evt,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int ROW_W      = ADDR_W - PAGE_BITS;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_COMMIT, S_HOLD} st_t;

  st_t                  st;
  logic [ROW_W-1:0]     row;
  logic [PAGE_BITS-1:0] ptr;
  logic [PAGE_BITS-1:0] idx;
  logic [CNT_W-1:0]     cnt;
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]           pbuf [PAGE_BYTES];

  logic                  take;
  logic [PAGE_BYTES-1:0] mask_nx;

  assign take    = (st == S_FILL) && byte_we && !rstart_evt && !addr_we;
  assign mask_nx = mask | (take ? (PAGE_BYTES'(1) << ptr) : '0);

  assign busy      = (st == S_COMMIT) || (st == S_HOLD);
  assign arr_we    = (st == S_COMMIT) && mask[idx] && !wp;
  assign arr_addr  = {row, idx};
  assign arr_wdata = pbuf[idx];

  always_ff @(posedge clk)
    if (take) pbuf[ptr] <= byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      row  <= '0;
      ptr  <= '0;
      idx  <= '0;
      cnt  <= '0;
      mask <= '0;
    end else begin
      case (st)
        S_IDLE, S_FILL: begin
          if (rstart_evt) begin
            st   <= S_IDLE;
            mask <= '0;
          end else if (addr_we) begin
            st   <= S_FILL;
            row  <= addr_in[ADDR_W-1:PAGE_BITS];
            ptr  <= addr_in[PAGE_BITS-1:0];
            mask <= '0;
          end else if (st == S_FILL) begin
            if (take) ptr <= ptr + 1'b1;
            if (stop_evt) begin
              if ((|mask_nx) && !wp) begin
                st   <= S_COMMIT;
                idx  <= '0;
                mask <= mask_nx;
              end else begin
                st   <= S_IDLE;
                mask <= '0;
              end
            end else begin
              mask <= mask_nx;
            end
          end
        end
        S_COMMIT: begin
          idx <= idx + 1'b1;
          if (&idx) begin
            st   <= S_HOLD;
            cnt  <= CNT_W'(WR_CYCLES);
            mask <= '0;
          end
        end
        default: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5,
  parameter int WR_CYCLES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              stop_evt,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int WIN = (1 << PAGE_BITS) + WR_CYCLES + 1;

  int unsigned len;
  always_ff @(posedge clk)
    if (!rst_n)    len <= 0;
    else if (busy) len <= len + 1;
    else           len <= 0;

  // R7
  wp_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n) !(arr_we && wp));

  // R5
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> len == WIN);

  // R4
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> busy);

  // R2
  row_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> $stable(arr_addr[ADDR_W-1:PAGE_BITS]));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .stop_evt(stop_evt),
  .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;
  localparam int AW = 12;
  localparam int PB = 5;
  localparam int WR = 20;
  localparam int WIN = (1 << PB) + WR + 1;

  logic clk = 0, rst_n = 0, wp = 0;
  logic addr_we = 0, byte_we = 0, stop_evt = 0, rstart_evt = 0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_BITS(PB), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .addr_we(addr_we), .addr_in(addr_in),
    .byte_we(byte_we), .byte_in(byte_in), .stop_evt(stop_evt), .rstart_evt(rstart_evt),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  logic [7:0] mem [1 << AW];
  logic [7:0] expm [1 << AW];
  int nwr = 0, checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) if (arr_we) begin mem[arr_addr] <= arr_wdata; nwr++; end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_addr(int a);
    @(negedge clk); addr_we = 1; addr_in = AW'(a);
    @(negedge clk); addr_we = 0;
  endtask
  task automatic pulse_byte(int b);
    @(negedge clk); byte_we = 1; byte_in = 8'(b);
    @(negedge clk); byte_we = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask
  task automatic pulse_byte_stop(int b);
    @(negedge clk); byte_we = 1; byte_in = 8'(b); stop_evt = 1;
    @(negedge clk); byte_we = 0; stop_evt = 0;
  endtask
  task automatic pulse_rstart();
    @(negedge clk); rstart_evt = 1;
    @(negedge clk); rstart_evt = 0;
  endtask

  function automatic int busy_len();
    return 0;
  endfunction

  task automatic measure_busy(output int n);
    n = 0;
    while (busy && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic quiet_busy(output int n);
    n = 0;
    for (int i = 0; i < 8; i++) begin if (busy) n++; @(negedge clk); end
  endtask

  task automatic mem_cmp(string req);
    int bad = 0;
    for (int i = 0; i < (1 << AW); i++) if (mem[i] !== expm[i]) bad++;
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", int'(busy), 0);
    check("R1 arr_we after reset", int'(arr_we), 0);
    check("R1 no writes after reset", nwr, 0);
  endtask

  task automatic t_single();
    int n, w0;
    w0 = nwr;
    pulse_addr('h123); pulse_byte('h3C); pulse_stop();
    expm['h123] = 8'h3C;
    measure_busy(n);
    check("R5 busy window length", n, WIN);
    check("R4 single byte write count", nwr - w0, 1);
    mem_cmp("R4 single byte, neighbours kept");
  endtask

  task automatic t_wrap();
    int n, w0;
    w0 = nwr;
    pulse_addr('h05E);
    for (int i = 0; i < 4; i++) pulse_byte('h50 + i);
    pulse_stop();
    expm['h05E] = 8'h50; expm['h05F] = 8'h51; expm['h040] = 8'h52; expm['h041] = 8'h53;
    measure_busy(n);
    check("R5 busy window wrap", n, WIN);
    check("R2 wrap write count", nwr - w0, 4);
    mem_cmp("R2 wrap within page row");
  endtask

  task automatic t_overflow();
    int n, w0;
    w0 = nwr;
    pulse_addr('h200);
    for (int i = 0; i < 34; i++) pulse_byte(i + 'h80);
    pulse_stop();
    for (int i = 0; i < 32; i++) expm['h200 + i] = 8'(i + 'h80);
    expm['h200] = 8'(32 + 'h80); expm['h201] = 8'(33 + 'h80);
    measure_busy(n);
    check("R3 overflow write count", nwr - w0, 32);
    mem_cmp("R3 overflow overwrites earlier bytes");
  endtask

  task automatic t_wp();
    int n, w0;
    w0 = nwr;
    wp = 1;
    pulse_addr('h300); pulse_byte('hEE); pulse_stop();
    quiet_busy(n);
    wp = 0;
    check("R7 no busy under write protect", n, 0);
    check("R7 no writes under write protect", nwr - w0, 0);
    mem_cmp("R7 array unchanged under write protect");
  endtask

  task automatic t_addr_only();
    int n, w0;
    w0 = nwr;
    pulse_addr('h310); pulse_stop();
    quiet_busy(n);
    check("R9 address-only starts no cycle", n, 0);
    check("R9 address-only writes nothing", nwr - w0, 0);
  endtask

  task automatic t_restart();
    int n, w0;
    w0 = nwr;
    pulse_addr('h320);
    for (int i = 0; i < 3; i++) pulse_byte('h11 + i);
    pulse_rstart(); pulse_stop();
    quiet_busy(n);
    check("R8 restart aborts, no busy", n, 0);
    check("R8 restart aborts, no writes", nwr - w0, 0);
    mem_cmp("R8 array unchanged after abort");
  endtask

  task automatic t_busy_ignore();
    int n, w0;
    w0 = nwr;
    pulse_addr('h330); pulse_byte('h77); pulse_stop();
    expm['h330] = 8'h77;
    pulse_addr('h400); pulse_byte('h22); pulse_stop();
    pulse_rstart();
    measure_busy(n);
    check("R5 busy window under traffic", n, WIN - 8);
    quiet_busy(n);
    check("R6 no second cycle from busy-time traffic", n, 0);
    check("R6 one write only", nwr - w0, 1);
    mem_cmp("R6 busy-time traffic ignored");
  endtask

  task automatic t_same_cycle();
    int n, w0;
    w0 = nwr;
    pulse_addr('h7FF); pulse_byte_stop('hC3);
    expm['h7FF] = 8'hC3;
    measure_busy(n);
    check("R10 byte with stop gives full window", n, WIN);
    check("R10 byte with stop written once", nwr - w0, 1);
    mem_cmp("R10 byte with stop reaches array");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = 8'(i) ^ 8'hA5; expm[i] = 8'(i) ^ 8'hA5; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_wp();
    t_addr_only();
    t_restart();
    t_busy_ignore();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule